// File: doc/BRIEF.md
# SD Card SPI-Mode Bring-Up Sequencer

This block walks a freshly inserted SD card through SPI-mode bring-up. It does not shift bits itself. It hands one request at a time to a separate command-frame engine, which sends a 6-byte command or a run of idle clocks and returns either the card's first response byte or a timeout. The sequencer chooses what to send next from that byte. It also drives a clock-select level that tells the SPI clock divider to run slow during bring-up and fast once the card is usable.

A pulse on `start` begins a run. The card first gets idle clocks with chip select released, then a software reset, then an interface-condition probe. The answer to the probe separates first-generation cards from second-generation cards. The block then repeats an application-prefix / operating-condition pair until the card leaves idle, or until the attempt budget runs out. Second-generation cards next have their operating-conditions register read. Every card then has its block length set. The run ends in a finished state that reports a card-type code, or in a failed state that raises `error`.

States: `ST_IDLE` (after reset), `ST_PRE` (idle clocks), `ST_RESET` (CMD0), `ST_IFCOND` (CMD8), `ST_APP` (CMD55), `ST_OPCOND` (CMD41), `ST_OCR` (CMD58), `ST_BLKLEN` (CMD16), `ST_DONE`, `ST_FAIL`. Transitions:
- IDLE/DONE/FAIL go to PRE on `start`.
- PRE goes to RESET.
- RESET goes to IFCOND on 0x01.
- IFCOND goes to APP on 0x01 or 0x05.
- APP goes to OPCOND.
- OPCOND goes to APP when the card is busy and attempts remain, to OCR on success for a second-generation card, and to BLKLEN on success for a first-generation card.
- OCR goes to BLKLEN.
- BLKLEN goes to DONE on 0x00.
- Every other response, and every timeout, leads to FAIL.

Top module: `sd_init_seq`

## Requirements
- R1: After `start`, the first request is idle clocks: `cmd_idle_clk`=1, `cmd_idx`=0, `cmd_arg`=PRE_BYTES (16), `cmd_crc`=0xFF.
- R2: The second request is index 0, argument 0, crc byte 0x95. Any first response byte other than 0x01 ends in failure.
- R3: The third request is index 8, argument 0x000001AA, crc byte 0x87. A response of 0x01 selects the second-generation path and 0x05 selects the first-generation path. Any other value ends in failure.
- R4: Each attempt is index 55 then index 41, both with argument 0 and crc byte 0xFF. A 0x00 response to index 41 ends the loop. After MAX_TRIES attempts that all answered nonzero, the run fails, and it never makes more than MAX_TRIES attempts.
- R5: On the second-generation path only, index 58 (argument 0) follows a successful index 41. The first-generation path skips it.
- R6: The last request is index 16 with argument BLK_LEN (512). Only a 0x00 response finishes successfully; anything else ends in failure.
- R7: On success `done`=1, `error`=0, and `card_type` is 1 for first-generation or 2 for second-generation. On failure `done`=1, `error`=1 and `card_type`=0. Code 3 is reserved for high capacity.
- R8: `clk_fast` is 0 from `start` until success. It rises only together with a successful finish and stays 0 after a failure.
- R9: A response with `resp_tout`=1 to any command ends the run in failure.
- R10: `start` has no effect while a run is in progress. It is accepted in the idle, finished and failed states.
- R11: After reset, `done`, `error`, `clk_fast`, `cmd_valid` and `card_type` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up run |
| cmd_valid | output | 1 | Request to the command engine is pending |
| cmd_ready | input | 1 | Engine takes the request this cycle |
| cmd_idle_clk | output | 1 | 1: send cmd_arg idle bytes with chip select high; 0: send a command |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument, or idle byte count |
| cmd_crc | output | 8 | Closing byte of the command frame |
| resp_valid | input | 1 | Engine result is present |
| resp_r1 | input | 8 | First response byte from the card |
| resp_tout | input | 1 | Engine gave up waiting for a response |
| clk_fast | output | 1 | SPI divider select: 0 slow, 1 fast |
| done | output | 1 | Run finished (success or failure) |
| error | output | 1 | Run failed |
| card_type | output | 2 | 0 fail, 1 first-gen, 2 second-gen, 3 reserved |

## Verification
A `start` seen at a rising edge makes the idle-clock request visible right after that edge. A result accepted at an edge makes the next request visible right after the same edge, so a new request appears one cycle after each result. `done`, `error`, `card_type` and `clk_fast` settle one edge after the final result. The bench drives and samples only on falling edges, half a cycle after any change. Its engine model captures each request at the falling edge before acceptance and answers two falling edges later.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PRE, ST_RESET, ST_IFCOND, ST_APP,
        ST_OPCOND, ST_OCR, ST_BLKLEN, ST_DONE, ST_FAIL
    } seq_state_e;

    localparam logic [1:0] TYPE_NONE = 2'd0;
    localparam logic [1:0] TYPE_V1   = 2'd1;
    localparam logic [1:0] TYPE_V2SC = 2'd2;
    localparam logic [1:0] TYPE_V2HC = 2'd3;

    localparam logic [5:0] IDX_RESET  = 6'd0;
    localparam logic [5:0] IDX_IFCOND = 6'd8;
    localparam logic [5:0] IDX_BLKLEN = 6'd16;
    localparam logic [5:0] IDX_OPCOND = 6'd41;
    localparam logic [5:0] IDX_APP    = 6'd55;
    localparam logic [5:0] IDX_OCR    = 6'd58;

    localparam logic [7:0] R1_IDLE         = 8'h01;
    localparam logic [7:0] R1_IDLE_ILLEGAL = 8'h05;
    localparam logic [7:0] R1_READY        = 8'h00;

endpackage

// File: rtl/sd_init_retry.sv
module sd_init_retry #(
    parameter int MAX_TRIES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bump,
    output logic last
);
    localparam int CW = $clog2(MAX_TRIES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (bump) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == CW'(MAX_TRIES - 1));

    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(MAX_TRIES)); // R4

endmodule

// File: rtl/sd_init_cmdsel.sv
module sd_init_cmdsel
    import sd_init_pkg::*;
#(
    parameter int PRE_BYTES = 16,
    parameter int BLK_LEN   = 512
) (
    input  seq_state_e  state,
    output logic        idle_clk,
    output logic [5:0]  idx,
    output logic [31:0] arg,
    output logic [7:0]  crc
);
    always_comb begin
        idle_clk = 1'b0;
        idx      = IDX_RESET;
        arg      = '0;
        crc      = 8'hFF;
        unique case (state)
            ST_PRE: begin
                idle_clk = 1'b1;
                arg      = 32'(PRE_BYTES);
            end
            ST_RESET:  crc = 8'h95;
            ST_IFCOND: begin
                idx = IDX_IFCOND;
                arg = 32'h0000_01AA;
                crc = 8'h87;
            end
            ST_APP:    idx = IDX_APP;
            ST_OPCOND: idx = IDX_OPCOND;
            ST_OCR:    idx = IDX_OCR;
            ST_BLKLEN: begin
                idx = IDX_BLKLEN;
                arg = 32'(BLK_LEN);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq
    import sd_init_pkg::*;
#(
    parameter int MAX_TRIES = 5000,
    parameter int PRE_BYTES = 16,
    parameter int BLK_LEN   = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        cmd_valid,
    input  logic        cmd_ready,
    output logic        cmd_idle_clk,
    output logic [5:0]  cmd_idx,
    output logic [31:0] cmd_arg,
    output logic [7:0]  cmd_crc,
    input  logic        resp_valid,
    input  logic [7:0]  resp_r1,
    input  logic        resp_tout,
    output logic        clk_fast,
    output logic        done,
    output logic        error,
    output logic [1:0]  card_type
);
    seq_state_e state, state_n;
    logic       waiting, waiting_n;
    logic       ver2, ver2_n;
    logic [1:0] type_q, type_n;
    logic       fast_q, fast_n;
    logic       try_clr, try_bump, try_last;

    sd_init_retry #(.MAX_TRIES(MAX_TRIES)) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (try_clr),
        .bump  (try_bump),
        .last  (try_last)
    );

    sd_init_cmdsel #(.PRE_BYTES(PRE_BYTES), .BLK_LEN(BLK_LEN)) u_cmdsel (
        .state    (state),
        .idle_clk (cmd_idle_clk),
        .idx      (cmd_idx),
        .arg      (cmd_arg),
        .crc      (cmd_crc)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            waiting <= 1'b0;
            ver2    <= 1'b0;
            type_q  <= TYPE_NONE;
            fast_q  <= 1'b0;
        end else begin
            state   <= state_n;
            waiting <= waiting_n;
            ver2    <= ver2_n;
            type_q  <= type_n;
            fast_q  <= fast_n;
        end
    end

    // next state
    always_comb begin
        state_n   = state;
        waiting_n = waiting;
        ver2_n    = ver2;
        type_n    = type_q;
        fast_n    = fast_q;
        try_clr   = 1'b0;
        try_bump  = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    state_n   = ST_PRE;
                    waiting_n = 1'b0;
                    type_n    = TYPE_NONE;
                    fast_n    = 1'b0;
                    try_clr   = 1'b1;
                end
            end
            default: begin
                if (!waiting) begin
                    if (cmd_ready) waiting_n = 1'b1;
                end else if (resp_valid) begin
                    waiting_n = 1'b0;
                    state_n   = ST_FAIL;
                    if (state == ST_PRE) begin
                        state_n = ST_RESET;
                    end else if (!resp_tout) begin
                        case (state)
                            ST_RESET:
                                if (resp_r1 == R1_IDLE) state_n = ST_IFCOND;
                            ST_IFCOND: begin
                                if (resp_r1 == R1_IDLE) begin
                                    ver2_n  = 1'b1;
                                    state_n = ST_APP;
                                end else if (resp_r1 == R1_IDLE_ILLEGAL) begin
                                    ver2_n  = 1'b0;
                                    state_n = ST_APP;
                                end
                            end
                            ST_APP: state_n = ST_OPCOND;
                            ST_OPCOND: begin
                                if (resp_r1 == R1_READY) begin
                                    state_n = ver2 ? ST_OCR : ST_BLKLEN;
                                end else if (!try_last) begin
                                    try_bump = 1'b1;
                                    state_n  = ST_APP;
                                end
                            end
                            ST_OCR: state_n = ST_BLKLEN;
                            ST_BLKLEN: begin
                                if (resp_r1 == R1_READY) begin
                                    state_n = ST_DONE;
                                    type_n  = ver2 ? TYPE_V2SC : TYPE_V1;
                                    fast_n  = 1'b1;
                                end
                            end
                            default: state_n = ST_FAIL;
                        endcase
                    end
                    if (state_n == ST_FAIL) type_n = TYPE_NONE;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        cmd_valid = 1'b0;
        done      = 1'b0;
        error     = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_DONE: done = 1'b1;
            ST_FAIL: begin
                done  = 1'b1;
                error = 1'b1;
            end
            default: cmd_valid = !waiting;
        endcase
        card_type = type_q;
        clk_fast  = fast_q;
    end

    AST_FAST_AFTER_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_fast |-> (done && !error)); // R8
    AST_FAIL_TYPE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (card_type == TYPE_NONE)); // R7
    AST_NO_REQ_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid); // R10
    AST_SUCCESS_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && !error) |-> ($past(resp_valid) && $past(resp_r1) == R1_READY
                                     && !$past(resp_tout))); // R6
    AST_TYPE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !error) |-> (card_type == TYPE_V1 || card_type == TYPE_V2SC)); // R7

endmodule

// File: tb/tb_sd_init_seq.sv
`timescale 1ns/1ps
module tb_sd_init_seq;
    localparam int TRIES = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cmd_valid, cmd_ready, cmd_idle_clk;
    logic [5:0]  cmd_idx;
    logic [31:0] cmd_arg;
    logic [7:0]  cmd_crc;
    logic        resp_valid, resp_tout;
    logic [7:0]  resp_r1;
    logic        clk_fast, done, error;
    logic [1:0]  card_type;

    int checks = 0;
    int errors = 0;

    // scenario knobs read by the engine model
    logic [7:0] sc_rst_r1, sc_if_r1, sc_blk_r1;
    int         sc_busy, sc_tout, op_seen;

    logic [46:0] exp_q[$];

    always #2.5 clk = ~clk;

    sd_init_seq #(.MAX_TRIES(TRIES)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_idle_clk(cmd_idle_clk),
        .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .cmd_crc(cmd_crc),
        .resp_valid(resp_valid), .resp_r1(resp_r1), .resp_tout(resp_tout),
        .clk_fast(clk_fast), .done(done), .error(error), .card_type(card_type)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input bit idle, input logic [5:0] idx, input logic [31:0] arg, input logic [7:0] crc);
        exp_q.push_back({idle, idx, arg, crc});
    endtask

    // engine model and monitor: captures each request, compares, answers
    initial begin
        cmd_ready = 1'b1; resp_valid = 1'b0; resp_r1 = 8'h00; resp_tout = 1'b0;
        forever begin
            @(negedge clk);
            resp_valid = 1'b0; resp_tout = 1'b0;
            if (cmd_valid) begin
                logic [46:0] got, want;
                logic [7:0]  r;
                logic        t;
                got = {cmd_idle_clk, cmd_idx, cmd_arg, cmd_crc};
                check(clk_fast == 1'b0, "R8 slow clock during bring-up", 64'(clk_fast), 64'd0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected extra request", 64'(got), 64'd0);
                end else begin
                    want = exp_q.pop_front();
                    check(got == want, "R1 R2 R3 R4 R5 R6 request order/content", 64'(got), 64'(want));
                end
                t = 1'b0; r = 8'hFF;
                if (!cmd_idle_clk) begin
                    t = (int'(cmd_idx) == sc_tout);
                    case (cmd_idx)
                        6'd0:  r = sc_rst_r1;
                        6'd8:  r = sc_if_r1;
                        6'd55: r = 8'h01;
                        6'd41: begin r = (op_seen < sc_busy) ? 8'h01 : 8'h00; op_seen++; end
                        6'd58: r = 8'h00;
                        6'd16: r = sc_blk_r1;
                        default: r = 8'hFF;
                    endcase
                end
                @(negedge clk);
                @(negedge clk);
                resp_valid = 1'b1; resp_r1 = r; resp_tout = t;
            end
        end
    end

    // driver: builds expected requests from the requirements, runs one case
    task automatic run_case(input string name, input logic [7:0] rst_r1, input logic [7:0] if_r1,
                            input int busy, input logic [7:0] blk_r1, input int tout, input bit poke);
        bit ok, v2, got;
        logic [1:0] etype;
        sc_rst_r1 = rst_r1; sc_if_r1 = if_r1; sc_busy = busy; sc_blk_r1 = blk_r1;
        sc_tout = tout; op_seen = 0; v2 = 1'b0; got = 1'b0;
        ok = 1'b1;
        push(1'b1, 6'd0, 32'd16, 8'hFF);                           // R1
        push(1'b0, 6'd0, 32'd0, 8'h95);                            // R2
        if (tout == 0 || rst_r1 != 8'h01) ok = 1'b0;
        if (ok) begin
            push(1'b0, 6'd8, 32'h1AA, 8'h87);                      // R3
            if (tout == 8 || !(if_r1 == 8'h01 || if_r1 == 8'h05)) ok = 1'b0;
            v2 = (if_r1 == 8'h01);
        end
        if (ok) begin
            for (int a = 0; a < TRIES && ok && !got; a++) begin   // R4
                push(1'b0, 6'd55, 32'd0, 8'hFF);
                if (tout == 55) ok = 1'b0;
                else begin
                    push(1'b0, 6'd41, 32'd0, 8'hFF);
                    if (tout == 41) ok = 1'b0;
                    else if (a >= busy) got = 1'b1;
                end
            end
            if (!got) ok = 1'b0;
        end
        if (ok && v2) begin
            push(1'b0, 6'd58, 32'd0, 8'hFF);                       // R5
            if (tout == 58) ok = 1'b0;
        end
        if (ok) begin
            push(1'b0, 6'd16, 32'd512, 8'hFF);                     // R6
            if (tout == 16 || blk_r1 != 8'h00) ok = 1'b0;
        end
        etype = ok ? (v2 ? 2'd2 : 2'd1) : 2'd0;

        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(done == 1'b0, "R10 start accepted after previous run", 64'(done), 64'd0);
        if (poke) begin
            repeat (12) @(negedge clk);
            start = 1'b1;                                           // R10 ignored while busy
            @(negedge clk); start = 1'b0;
        end
        while (!done) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("case %s", name);
        check(error == !ok, "R7 R9 error flag", 64'(error), 64'(!ok));
        check(card_type == etype, "R7 card type", 64'(card_type), 64'(etype));
        check(clk_fast == ok, "R8 clock select at end", 64'(clk_fast), 64'(ok));
        check(exp_q.size() == 0, "R10 all expected requests issued", 64'(exp_q.size()), 64'd0);
        exp_q.delete();
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 0 && error == 0 && clk_fast == 0 && cmd_valid == 0 && card_type == 0,
              "R11 reset state", 64'({done, error, clk_fast, cmd_valid, card_type}), 64'd0);
        run_case("v2 two busy + poke", 8'h01, 8'h01, 2, 8'h00, -1, 1'b1);   // R3 R5 R10
        run_case("v1 ready", 8'h01, 8'h05, 0, 8'h00, -1, 1'b0);             // R3 R5
        run_case("reset bad", 8'h00, 8'h01, 0, 8'h00, -1, 1'b0);            // R2
        run_case("ifcond bad", 8'h01, 8'h04, 0, 8'h00, -1, 1'b0);           // R3
        run_case("never ready", 8'h01, 8'h01, 99, 8'h00, -1, 1'b0);         // R4
        run_case("ready last try", 8'h01, 8'h05, TRIES - 1, 8'h00, -1, 1'b0); // R4
        run_case("blklen bad", 8'h01, 8'h01, 0, 8'h40, -1, 1'b0);           // R6
        run_case("tout app", 8'h01, 8'h01, 1, 8'h00, 55, 1'b0);             // R9
        run_case("tout ocr", 8'h01, 8'h01, 0, 8'h00, 58, 1'b0);             // R9
        run_case("tout reset", 8'h01, 8'h01, 0, 8'h00, 0, 1'b0);            // R9
        run_case("v2 again", 8'h01, 8'h01, 0, 8'h00, -1, 1'b0);             // R7
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule